// File: doc/BRIEF.md
# Erasable Byte Memory Array Model

This block is a synthesizable model of an electrically erasable, byte-wide nonvolatile array. A host reads bytes asynchronously through an output bus that is high-impedance unless the part is selected and read-enabled. It changes contents through timed commands that write one byte or return bits to the erased value 8'hFF. Erasing works on a single byte, on an aligned group of 4, 8 or 16 bytes, or on a whole sector.

Programming is allowed only on a location that already holds 8'hFF, which forces the erase-before-write discipline of real floating-gate storage. Every erase raises a wear count for the sector it touches. A flag reports once any sector has been erased more often than its rated endurance. The sector size is 2**SECTOR_W bytes, so SECTOR_W=12 gives 4K sectors and SECTOR_W=14 gives 16K sectors. Each command keeps the block busy for a fixed number of clock cycles set by a parameter.

Top module: `nvm_byte_store`

## Requirements
- R1: While rst_n is low, and after it is released, every location reads 8'hFF and busy, done, err and worn are 0.
- R2: dout_oe is 1 and dout equals the byte at addr when cs_n and rd_n are both 0. Otherwise dout_oe is 0 and dout is high-impedance.
- R3: A command is accepted when go is 1, busy is 0, cs_n is 0 and cmd is 3'd1 to 3'd6. Command 3'd1 (program) writes din to addr. If that location does not hold 8'hFF, the command is rejected: busy stays 0, err reads 1 after the edge, and the array is unchanged.
- R4: Command 3'd2 sets the byte at addr to 8'hFF.
- R5: Commands 3'd3, 3'd4 and 3'd5 set to 8'hFF the 4, 8 or 16 bytes of the group holding addr, aligned down to the group size. Bytes outside the group keep their values.
- R6: Command 3'd6 sets to 8'hFF every byte of the sector holding addr, aligned down to 2**SECTOR_W. Other sectors keep their values.
- R7: After an accepted command, busy is high for exactly SECT_CYC cycles for a sector erase and BYTE_CYC cycles for any other command. done pulses for one cycle in the cycle busy falls, and the new contents are readable from that cycle.
- R8: go is ignored while busy is 1, while cs_n is 1, and with cmd 3'd0 or 3'd7.
- R9: Each completed erase command adds one to the wear count of the sector holding its address. worn goes to 1 once any sector's count exceeds ENDURANCE, and stays 1 until reset.
- R10: An accepted command that is not rejected clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; fills the array with 8'hFF |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| go | input | 1 | Command start strobe |
| cmd | input | 3 | Command code |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Read data, high-impedance when not driven |
| dout_oe | output | 1 | 1 while dout is driven |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last program was rejected because the location was not erased |
| worn | output | 1 | A sector exceeded its erase endurance |

## Verification
Directed sequences show that a program to an erased byte succeeds and that a second program to the same byte is refused. They show that each group width clears exactly its aligned window and leaves the bytes just outside it intact, and that a sector erase stops at the sector boundary. Commands given while busy, while deselected, or with unused codes must leave no trace in the data that is read back afterwards. A wear run erases one sector up to its limit and then once past it, which separates an off-by-one in the endurance compare from a correct one. A seeded random mix of programs and erases over a small address window then produces many collisions. This tests rejection against a bench model of the array and checks the busy length of every command.

// File: rtl/nvm_byte_store.sv
module nvm_byte_store #(
  parameter int ADDR_W    = 10,
  parameter int SECTOR_W  = 8,
  parameter int BYTE_CYC  = 4,
  parameter int SECT_CYC  = 16,
  parameter int ENDURANCE = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              go,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              worn
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NSECT = 1 << (ADDR_W - SECTOR_W);
  localparam int SW    = ADDR_W - SECTOR_W;
  localparam int CW    = $clog2(SECT_CYC + 1);
  localparam int WCW   = $clog2(ENDURANCE + 2);

  localparam logic [2:0] OP_PROG = 3'd1;
  localparam logic [2:0] OP_EB   = 3'd2;
  localparam logic [2:0] OP_E4   = 3'd3;
  localparam logic [2:0] OP_E8   = 3'd4;
  localparam logic [2:0] OP_E16  = 3'd5;
  localparam logic [2:0] OP_ES   = 3'd6;

  logic [7:0]        mem [DEPTH];
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] span;
  logic [7:0]        din_q;
  logic [CW-1:0]     cnt;
  logic [NSECT-1:0]  over;

  wire valid    = (cmd != 3'd0) && (cmd != 3'd7);
  wire accept   = go && !busy && !cs_n && valid;
  wire reject   = accept && (cmd == OP_PROG) && (mem[addr] != 8'hFF);
  wire start    = accept && !reject;
  wire commit   = busy && (cnt == '0);
  wire is_erase = (op_q != OP_PROG);

  assign dout_oe = !cs_n && !rd_n;
  assign dout    = dout_oe ? mem[addr] : 8'bz;
  assign worn    = |over;

  always_comb begin
    case (op_q)
      OP_E4:   span = ADDR_W'(3);
      OP_E8:   span = ADDR_W'(7);
      OP_E16:  span = ADDR_W'(15);
      OP_ES:   span = ADDR_W'((1 << SECTOR_W) - 1);
      default: span = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      cnt    <= '0;
      op_q   <= '0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      done <= 1'b0;
      if (reject) err <= 1'b1;
      if (start) begin
        busy   <= 1'b1;
        err    <= 1'b0;
        cnt    <= (cmd == OP_ES) ? CW'(SECT_CYC - 1) : CW'(BYTE_CYC - 1);
        op_q   <= cmd;
        addr_q <= addr;
        din_q  <= din;
      end else if (commit) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (is_erase && ((ADDR_W'(i) & ~span) == (addr_q & ~span)))
          mem[i] <= 8'hFF;
        else if (!is_erase && (ADDR_W'(i) == addr_q))
          mem[i] <= din_q;
      end
    end
  end

  for (genvar s = 0; s < NSECT; s++) begin : g_wear
    logic [WCW-1:0] wc;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wc <= '0;
      else if (commit && is_erase && (addr_q[ADDR_W-1:SECTOR_W] == SW'(s))
               && (wc != WCW'(ENDURANCE + 1)))
        wc <= wc + 1'b1;
    end
    assign over[s] = (wc > WCW'(ENDURANCE));
  end
endmodule

// File: rtl/nvm_byte_store_chk.sv
module nvm_byte_store_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              worn,
  input logic [2:0]        op_q,
  input logic [ADDR_W-1:0] addr_q
);
  a_r8_busy_holds_op: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go |=> $stable(op_q) && $stable(addr_q));
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r3_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !$past(busy));
  a_r9_worn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    worn |=> worn);
endmodule

bind nvm_byte_store nvm_byte_store_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .err(err), .worn(worn), .op_q(op_q), .addr_q(addr_q)
);

// File: tb/nvm_byte_store_tb_top.sv
module nvm_byte_store_tb_top;
  localparam int AW = 10, SW = 8, BC = 4, SC = 16, EN = 5;
  localparam int DEPTH = 1 << AW, NS = 1 << (AW - SW);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, rd_n, go;
  logic [2:0] cmd;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  logic dout_oe, busy, done, err, worn;

  int checks = 0, fails = 0;
  logic [7:0] ref_mem [DEPTH];
  int ref_wear [NS];

  nvm_byte_store #(.ADDR_W(AW), .SECTOR_W(SW), .BYTE_CYC(BC), .SECT_CYC(SC),
                   .ENDURANCE(EN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .go(go), .cmd(cmd),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .busy(busy),
    .done(done), .err(err), .worn(worn));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int span_of(input int op);
    case (op)
      3: return 3;
      4: return 7;
      5: return 15;
      6: return (1 << SW) - 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_worn();
    for (int s = 0; s < NS; s++) if (ref_wear[s] > EN) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; go = 1'b0; cs_n = 1'b0; rd_n = 1'b1;
    cmd = '0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    for (int s = 0; s < NS; s++) ref_wear[s] = 0;
  endtask

  task automatic read_chk(input int a, input string req);
    @(negedge clk);
    addr = AW'(a); rd_n = 1'b0; cs_n = 1'b0;
    #1;
    chk(dout_oe === 1'b1 && dout === ref_mem[a], req, int'(dout), int'(ref_mem[a]));
    rd_n = 1'b1;
  endtask

  task automatic issue(input int op, input int a, input int d, input string req);
    int n, sp;
    @(negedge clk);
    cmd = 3'(op); addr = AW'(a); din = 8'(d); go = 1'b1; cs_n = 1'b0;
    @(negedge clk);
    go = 1'b0;
    if (op == 0 || op == 7) begin
      chk(busy == 1'b0, "R8", busy, 0);
      return;
    end
    if (op == 1 && ref_mem[a] != 8'hFF) begin
      chk(busy == 1'b0 && err == 1'b1, "R3", {busy, err}, 1);
      read_chk(a, "R3");
      return;
    end
    chk(err == 1'b0, "R10", err, 0);
    n = 0;
    while (!done) begin
      if (busy) n++;
      @(negedge clk);
    end
    chk(n == ((op == 6) ? SC : BC), "R7", n, (op == 6) ? SC : BC);
    sp = span_of(op);
    if (op == 1) ref_mem[a] = 8'(d);
    else begin
      for (int i = 0; i < DEPTH; i++)
        if ((i & ~sp) == (a & ~sp)) ref_mem[i] = 8'hFF;
      ref_wear[a >> SW]++;
    end
    chk(worn == exp_worn(), "R9", worn, exp_worn());
    read_chk(a, req);
    read_chk(((a | sp) + 1) % DEPTH, req);
    read_chk(((a & ~sp) + DEPTH - 1) % DEPTH, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R1 reset state
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && worn == 0, "R1", {busy, done, err, worn}, 0);
    read_chk(0, "R1"); read_chk(DEPTH - 1, "R1"); read_chk(300, "R1");
    // R2 output enable
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
    chk(dout_oe == 1'b0, "R2", dout_oe, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(dout_oe == 1'b0, "R2", dout_oe, 0);
    cs_n = 1'b0; rd_n = 1'b1;
    // R3 program and reject, R10 clear
    issue(1, 'h10, 'hA5, "R3");
    issue(1, 'h10, 'h00, "R3");
    issue(1, 'h05, 'h5A, "R10");
    // R4 byte erase
    issue(2, 'h10, 0, "R4");
    // R5 groups
    for (int i = 'h20; i < 'h40; i++) issue(1, i, i ^ 'h55, "R3");
    issue(4, 'h2B, 0, "R5");
    issue(3, 'h21, 0, "R5");
    issue(5, 'h3F, 0, "R5");
    // R6 sector
    issue(1, 'h0FF, 'h11, "R3"); issue(1, 'h100, 'h22, "R3");
    issue(1, 'h1FF, 'h33, "R3"); issue(1, 'h200, 'h44, "R3");
    issue(6, 'h155, 0, "R6");
    read_chk('h0FF, "R6"); read_chk('h200, "R6");
    // R8 go while busy
    @(negedge clk); cmd = 3'd1; addr = AW'('h300); din = 8'h3C; go = 1'b1;
    @(negedge clk); cmd = 3'd6; addr = AW'('h005);
    @(negedge clk); go = 1'b0;
    while (!done) @(negedge clk);
    ref_mem['h300] = 8'h3C;
    read_chk('h300, "R8"); read_chk('h005, "R8");
    // R8 deselected
    @(negedge clk); cs_n = 1'b1; cmd = 3'd2; addr = AW'('h005); go = 1'b1;
    @(negedge clk); go = 1'b0; cs_n = 1'b0;
    chk(busy == 1'b0, "R8", busy, 0);
    read_chk('h005, "R8");
    issue(7, 'h005, 0, "R8"); issue(0, 'h005, 0, "R8");
    read_chk('h005, "R8");
    // R9 wear on sector 2
    do_reset();
    for (int k = 0; k <= EN; k++) issue(2, 'h210 + k, 0, "R9");
    chk(worn == 1'b1, "R9", worn, 1);
    issue(2, 'h010, 0, "R9");
    chk(worn == 1'b1, "R9", worn, 1);
    // random mix
    do_reset();
    for (int k = 0; k < 300; k++) begin
      int r, op, a;
      r = $urandom_range(0, 99);
      op = (r < 65) ? 1 : (r < 75) ? 2 : (r < 82) ? 3 : (r < 88) ? 4 :
           (r < 93) ? 5 : (r < 96) ? 6 : ((r & 1) ? 7 : 0);
      a = (($urandom_range(0, 3)) << SW) | $urandom_range(0, 31);
      issue(op, a, $urandom_range(0, 255), (op == 1) ? "R3" : "R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule